// File: doc/BRIEF.md
# Set-Associative Read-Allocate Cache Controller

This block sits between a processor port and a slow main memory. It serves 32-bit reads and writes on 32-bit byte addresses. The processor raises a request and holds it until the block raises ready. A cacheable read whose word is already held completes in the same cycle, without any memory traffic. Every other access starts a single-word memory transaction on a request/acknowledge handshake whose latency can vary. The processor waits until the memory acknowledges.

At elaboration the block is built as either one way (direct-mapped) or two ways. Each line covers an 8-word block under a single tag and a line-valid flag, and every word in the line has its own valid flag. A line can therefore fill up one word at a time. A read miss loads only the requested word. Writes always go through to memory. A write updates the cached copy only when that word is already present, and a write miss allocates nothing. A per-access uncached flag sends the access to memory and leaves the cache untouched, for example for I/O registers. In a two-way build, each set keeps a single bit that records the way used last.

The address is split, from low bits to high bits, into a 2-bit byte offset, a 3-bit word select, the set index, and the tag. With `LINES_W` = 10 this gives a 17-bit tag over 1024 lines in the one-way build, and an 18-bit tag over 512 sets in the two-way build. The default build uses `LINES_W` = 5 with two ways, so it has 16 sets and a 23-bit tag.

Top module: `sa_cache`

## Requirements
- R1: After reset, `cpu_ready` and `mem_req` are low while no request is pending, and every line is invalid, so the first read of any address misses.
- R2: The word select is `cpu_addr[4:2]`. The set index is the `LINES_W-1` bits above it in the two-way build, or `LINES_W` bits in the one-way build. The tag is the remaining upper bits. The byte offset `cpu_addr[1:0]` plays no part in lookup.
- R3: A cacheable read that hits raises `cpu_ready` in the same cycle as `cpu_req`, with the cached word on `cpu_rdata`. `mem_req` stays low for that access.
- R4: Any access that is not a read hit raises `mem_req` in the cycle after the request, with `mem_addr` equal to `cpu_addr`. `cpu_ready` rises in the cycle in which `mem_ack` is high. For a read, `cpu_rdata` then equals `mem_rdata`.
- R5: A read miss that needs a new line clears all word-valid flags of the victim way, loads the new tag, sets line valid, and marks only the fetched word valid. Other words of that line then still miss.
- R6: A read miss whose tag matches a valid line, but whose word is not yet valid, fills that word into the matching way. The words already valid in that line are kept.
- R7: A hit needs all three: a tag match, the line-valid flag, and the valid flag of the selected word.
- R8: The victim way for a new line is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way not used last. Read hits, fills and write hits each record their way as used last.
- R9: Every cacheable write goes to memory with `mem_we` high, the address and the data. If the word is cached, the cached copy takes the new data, so a later read hit returns it.
- R10: A write miss allocates nothing, so a following read of the same address misses.
- R11: An access with `cpu_uncached` high always goes to memory. It never fills, updates, or changes the used-last state of the cache, even when the address is cached.
- R12: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. It drops in the cycle after the acknowledge, so each access makes at most one memory transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_uncached | input | 1 | Bypass the cache for this access |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory transaction completes at this clock edge |

## Verification
A wrong valid flag, tag or used-last bit changes an access's latency at the ports. A stored word that should hit instead takes the slow memory path, or a word that should miss returns in zero wait cycles. Either shows on the very next access to that set. A cached word that is stale or missing shows on `cpu_rdata` at the next read hit of that word. A broken victim choice shows only after a third tag has entered a full set, as a miss on the way that should have survived. The bench therefore tracks the expected cache contents and compares the latency and data of every access.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_MEM  = 1'b1
   } cache_st_e;
endpackage

// File: rtl/cache_store.sv
// Tag, valid and data arrays, one set of register arrays per way.
module cache_store #(
   parameter int WAYS   = 2,
   parameter int SET_W  = 4,
   parameter int WSEL_W = 3,
   parameter int TAG_W  = 23,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SET_W-1:0]             set_i,
   input  logic [WSEL_W-1:0]            word_i,
   input  logic [TAG_W-1:0]             tag_i,
   output logic [WAYS-1:0]              line_valid_o,
   output logic [WAYS-1:0]              tag_match_o,
   output logic [WAYS-1:0]              word_hit_o,
   output logic [WAYS-1:0][DATA_W-1:0]  rdata_o,
   input  logic [WAYS-1:0]              wr_way_i,
   input  logic                         wr_alloc_i,
   input  logic [DATA_W-1:0]            wdata_i
);
   localparam int SETS  = 1 << SET_W;
   localparam int WORDS = 1 << WSEL_W;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0]  tag_q  [SETS];
      logic [SETS-1:0]   lv_q;
      logic [WORDS-1:0]  wv_q   [SETS];
      logic [DATA_W-1:0] data_q [SETS*WORDS];
      logic              match;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lv_q <= '0;
            for (int s = 0; s < SETS; s++) wv_q[s] <= '0;
         end else if (wr_way_i[w]) begin
            if (wr_alloc_i) begin
               lv_q[set_i] <= 1'b1;
               wv_q[set_i] <= WORDS'(1) << word_i;
            end else begin
               wv_q[set_i][word_i] <= 1'b1;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (wr_way_i[w]) begin
            data_q[{set_i, word_i}] <= wdata_i;
            if (wr_alloc_i) tag_q[set_i] <= tag_i;
         end
      end

      assign match           = lv_q[set_i] && (tag_q[set_i] == tag_i);
      assign line_valid_o[w] = lv_q[set_i];
      assign tag_match_o[w]  = match;
      assign word_hit_o[w]   = match && wv_q[set_i][word_i];
      assign rdata_o[w]      = data_q[{set_i, word_i}];
   end
endmodule

// File: rtl/cache_lru.sv
// Used-last bit per set and victim choice.
module cache_lru #(
   parameter int WAYS  = 2,
   parameter int SET_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_i,
   input  logic [WAYS-1:0]  line_valid_i,
   input  logic             touch_i,
   input  logic             touch_way_i,
   output logic             victim_o
);
   localparam int SETS = 1 << SET_W;

   if (WAYS == 2) begin : g_two
      logic [SETS-1:0] last_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       last_q <= '0;
         else if (touch_i) last_q[set_i] <= touch_way_i;
      end

      always_comb begin
         if (!line_valid_i[0])      victim_o = 1'b0;
         else if (!line_valid_i[1]) victim_o = 1'b1;
         else                       victim_o = ~last_q[set_i];
      end
   end else begin : g_one
      assign victim_o = 1'b0;
   end
endmodule

// File: rtl/sa_cache.sv
module sa_cache
   import cache_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int WAYS    = 2,
   parameter int LINES_W = 5,
   parameter int WSEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              cpu_uncached,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int BYTE_W = 2;
   localparam int SET_W  = LINES_W - ((WAYS == 2) ? 1 : 0);
   localparam int TAG_W  = ADDR_W - SET_W - WSEL_W - BYTE_W;

   if (WAYS != 1 && WAYS != 2) begin : g_bad_ways
      $error("sa_cache: WAYS must be 1 or 2");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("sa_cache: DATA_W must be 32 for a 2-bit byte offset");
   end
   if (TAG_W < 1 || SET_W < 1) begin : g_bad_split
      $error("sa_cache: address split leaves no tag or index bits");
   end

   logic [SET_W-1:0]  a_set;
   logic [WSEL_W-1:0] a_word;
   logic [TAG_W-1:0]  a_tag;

   assign a_word = cpu_addr[BYTE_W +: WSEL_W];
   assign a_set  = cpu_addr[BYTE_W+WSEL_W +: SET_W];
   assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

   logic [WAYS-1:0]             line_valid, tag_match, word_hit, wr_way;
   logic [WAYS-1:0][DATA_W-1:0] way_rdata;
   logic                        wr_alloc, victim, hit_idx, match_idx, fill_idx;
   logic [DATA_W-1:0]           wr_data;

   cache_st_e st_q, st_d;
   logic hit, rd_hit_now, done, fill_now, wupd;

   assign hit        = (|word_hit) && !cpu_uncached;
   assign rd_hit_now = (st_q == ST_IDLE) && cpu_req && !cpu_we && hit;
   assign done       = (st_q == ST_MEM) && mem_ack;
   assign fill_now   = done && !cpu_we && !cpu_uncached;
   assign wupd       = done && cpu_we && hit;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (cpu_req && !rd_hit_now) st_d = ST_MEM;
         ST_MEM:  if (mem_ack)                st_d = ST_IDLE;
         default:                             st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   if (WAYS == 2) begin : g_idx2
      assign hit_idx   = word_hit[1];
      assign match_idx = tag_match[1];
   end else begin : g_idx1
      assign hit_idx   = 1'b0;
      assign match_idx = 1'b0;
   end

   assign fill_idx = (|tag_match) ? match_idx : victim;
   assign wr_alloc = fill_now && !(|tag_match);
   assign wr_data  = fill_now ? mem_rdata : cpu_wdata;
   assign wr_way   = fill_now ? (WAYS'(1) << fill_idx) : (wupd ? word_hit : '0);

   cache_store #(
      .WAYS(WAYS), .SET_W(SET_W), .WSEL_W(WSEL_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .set_i(a_set), .word_i(a_word), .tag_i(a_tag),
      .line_valid_o(line_valid), .tag_match_o(tag_match), .word_hit_o(word_hit),
      .rdata_o(way_rdata), .wr_way_i(wr_way), .wr_alloc_i(wr_alloc), .wdata_i(wr_data)
   );

   cache_lru #(.WAYS(WAYS), .SET_W(SET_W)) u_lru (
      .clk(clk), .rst_n(rst_n), .set_i(a_set), .line_valid_i(line_valid),
      .touch_i(rd_hit_now || fill_now || wupd),
      .touch_way_i(fill_now ? fill_idx : hit_idx),
      .victim_o(victim)
   );

   assign cpu_ready = rd_hit_now || done;
   assign cpu_rdata = done ? mem_rdata : way_rdata[hit_idx];
   assign mem_req   = (st_q == ST_MEM);
   assign mem_we    = cpu_we;
   assign mem_addr  = cpu_addr;
   assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_uncached,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req && !mem_req) |-> !cpu_ready);

   p_fast_only_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready && !mem_ack) |-> (!mem_req && !cpu_we && !cpu_uncached));

   p_miss_goes_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_ready) |=> mem_req);

   p_ack_completes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |-> cpu_ready);

   p_write_via_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && cpu_ready) |-> mem_ack);

   p_uncached_via_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_uncached && cpu_ready) |-> mem_ack);

   p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   p_single_txn_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> !mem_req);
endmodule

bind sa_cache sa_cache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sa_cache.sv
`timescale 1ns/1ps
module sim_sa_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_uncached = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   sa_cache u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_uncached(cpu_uncached), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // Memory image: tags 0..3 only, so addr[10:2] is a unique index.
   logic [31:0] bmem [512];

   // Expected cache contents (default build: 2 ways, 16 sets, 8 words).
   logic        m_lv   [2][16];
   logic [22:0] m_tag  [2][16];
   logic [7:0]  m_wv   [2][16];
   logic [31:0] m_data [2][16][8];
   int          m_last [16];

   function automatic logic [31:0] mkaddr(int tag, int set, int word);
      return (32'(tag) << 9) | (32'(set) << 5) | (32'(word) << 2);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Predicts latency class and data, then updates the expected contents.
   task automatic model(input logic we, input logic nc, input logic [31:0] addr,
                        input logic [31:0] wdata, output bit fast,
                        output logic [31:0] data);
      int s, wd, hw, mw, v;
      logic [22:0] t;
      s  = int'(addr[8:5]);
      wd = int'(addr[4:2]);
      t  = addr[31:9];
      hw = -1;
      mw = -1;
      for (int w = 0; w < 2; w++) begin
         if (m_lv[w][s] && m_tag[w][s] == t) begin
            mw = w;
            if (m_wv[w][s][wd]) hw = w;
         end
      end
      data = bmem[addr[10:2]];
      fast = 1'b0;
      if (nc) return;
      if (!we) begin
         if (hw >= 0) begin
            fast = 1'b1;
            data = m_data[hw][s][wd];
            m_last[s] = hw;
         end else if (mw >= 0) begin
            m_wv[mw][s][wd] = 1'b1;
            m_data[mw][s][wd] = data;
            m_last[s] = mw;
         end else begin
            if (!m_lv[0][s])      v = 0;
            else if (!m_lv[1][s]) v = 1;
            else                  v = 1 - m_last[s];
            m_lv[v][s] = 1'b1;
            m_tag[v][s] = t;
            m_wv[v][s] = 8'(1) << wd;
            m_data[v][s][wd] = data;
            m_last[s] = v;
         end
      end else if (hw >= 0) begin
         m_data[hw][s][wd] = wdata;
         m_last[s] = hw;
      end
   endtask

   // want: -1 use model latency, 0 expect slow path, 1 expect hit path.
   task automatic access(input logic we, input logic nc, input logic [31:0] addr,
                         input logic [31:0] wdata, input int want, input string req);
      bit fast_exp, fast;
      logic [31:0] dexp;
      model(we, nc, addr, wdata, fast_exp, dexp);
      if (want >= 0) fast_exp = (want == 1);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_uncached = nc;
      cpu_addr = addr; cpu_wdata = wdata;
      #1;
      fast = cpu_ready;
      if (fast) chk(!mem_req, "R3", "mem_req on hit", 32'(mem_req), 32'd0);
      while (!cpu_ready) begin
         @(negedge clk);
         #1;
      end
      if (!fast) begin
         chk(mem_addr == addr && mem_we == we, we ? "R9" : "R4",
             "memory address", mem_addr, addr);
      end
      chk(fast == fast_exp, req, "zero-wait completion", 32'(fast), 32'(fast_exp));
      if (!we) chk(cpu_rdata == dexp, req, "read data", cpu_rdata, dexp);
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
   endtask

   // Memory responder with 0..3 cycles of extra latency.
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req && !mem_ack) begin
            repeat ($urandom % 4) @(negedge clk);
            mem_rdata = bmem[mem_addr[10:2]];
            if (mem_we) bmem[mem_addr[10:2]] = mem_wdata;
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] a, b, c;
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 512; i++) bmem[i] = (32'(i) * 32'h9E37_79B9) ^ 32'hA5A5_0000;
      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 16; s++) begin
            m_lv[w][s] = 1'b0; m_wv[w][s] = '0; m_tag[w][s] = '0;
         end
      for (int s = 0; s < 16; s++) m_last[s] = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!cpu_ready, "R1", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
      chk(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 32'd0);

      a = mkaddr(0, 1, 2);
      b = mkaddr(1, 1, 2);
      c = mkaddr(2, 1, 0);
      access(0, 0, a, 0, 0, "R1");            // cold miss
      access(0, 0, a, 0, 1, "R3");            // hit
      access(0, 0, a | 32'd3, 0, 1, "R2");    // byte offset ignored
      access(0, 0, mkaddr(0, 2, 2), 0, 0, "R2"); // other set index
      access(0, 0, mkaddr(0, 1, 3), 0, 0, "R5"); // neighbour word not valid
      access(0, 0, a, 0, 1, "R6");            // earlier word kept
      access(0, 0, mkaddr(0, 1, 3), 0, 1, "R6");
      access(0, 0, b, 0, 0, "R7");            // same set/word, other tag
      access(0, 0, a, 0, 1, "R8");            // both ways held
      access(0, 0, b, 0, 1, "R8");
      access(0, 0, a, 0, 1, "R8");            // a used last
      access(0, 0, c, 0, 0, "R8");            // evicts b
      access(0, 0, a, 0, 1, "R8");
      access(0, 0, b, 0, 0, "R8");            // b was the victim
      access(1, 0, a, 32'hDEAD_BEEF, 0, "R9");
      access(0, 0, a, 0, 1, "R9");            // new data from cache
      access(1, 0, mkaddr(3, 5, 1), 32'h1234_5678, 0, "R10");
      access(0, 0, mkaddr(3, 5, 1), 0, 0, "R10");
      access(0, 1, mkaddr(0, 7, 0), 0, 0, "R11");
      access(0, 0, mkaddr(0, 7, 0), 0, 0, "R11"); // no fill from uncached read
      access(0, 1, a, 0, 0, "R11");            // cached address still bypasses
      access(1, 1, a, 32'h0BAD_F00D, 0, "R11");
      access(0, 0, a, 0, 1, "R11");            // cached copy untouched
      access(0, 0, a, 0, 1, "R12");

      for (int i = 0; i < 600; i++) begin
         int kind;
         logic [31:0] ra;
         ra = mkaddr(int'($urandom % 4), int'($urandom % 16), int'($urandom % 8));
         kind = int'($urandom % 10);
         if (kind < 6)      access(0, 0, ra, 0, -1, "R3");
         else if (kind < 8) access(1, 0, ra, $urandom, -1, "R9");
         else if (kind < 9) access(0, 1, ra, 0, -1, "R11");
         else               access(1, 1, ra, $urandom, -1, "R11");
      end

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule